// File: doc/BRIEF.md
# Windowed Watchdog Trigger Checker

This block supervises a microcontroller's periodic toggling of a watchdog line. It arms itself when the reset-pulse output of the surrounding supervisor falls from high to low. From then on it expects a first level change on the watchdog line within a generous start-up limit. After that first change, every later change must land inside a two-sided window measured from the previous one. Time is counted in 1 ms ticks provided from outside. The watchdog line arrives already synchronized.

A change that arrives before the lower window edge is a fault. So is a change that never arrives before the upper edge. Either fault produces a single-cycle reset request. The supervisor uses that request to fire a new reset pulse. After a request the checker stays idle until the next falling edge of the reset pulse. A disable input holds the checker idle and cleared. The supervisor drives it while its ignition-delay timer runs.

Top module: `wdw_trigger_checker`

## Requirements
- R1: After synchronous reset, `reset_req` is 0 and the checker is idle.
- R2: While idle, watchdog toggles and ticks of any number never raise `reset_req`. Only a high-to-low transition of `rp_level` (1 in one cycle, 0 in the next) arms the checker.
- R3: After arming, the tick count starts at 0. A watchdog change, rising or falling, seen while the count is at most START_MAX (500) is accepted as the first trigger and opens the windowed phase with the count at 0.
- R4: If no change comes in the start-up phase, a tick that arrives while the count already equals START_MAX raises `reset_req` in the following clock cycle.
- R5: In the windowed phase, a change seen with the count between WIN_MIN (200) and WIN_MAX (300), both bounds included, is accepted and restarts the count at 0.
- R6: In the windowed phase, a change seen with the count below WIN_MIN raises `reset_req` in the following cycle.
- R7: In the windowed phase, a tick with no change in the same cycle, arriving while the count equals WIN_MAX, raises `reset_req` in the following cycle.
- R8: When a change and a tick arrive in the same cycle, the change is judged on the count before that tick. If the change is accepted, the tick is discarded.
- R9: `reset_req` is high for exactly one cycle. Afterwards the checker is idle until the next `rp_level` falling edge, as in R2.
- R10: While `hold_off` is 1, the checker is idle with its count cleared and raises no request. After release it stays idle until the next `rp_level` falling edge.
- R11: An `rp_level` falling edge while already armed restarts the start-up phase with the count at 0. No request is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| wd_in | input | 1 | Synchronized watchdog line from the microcontroller |
| rp_level | input | 1 | Current level of the reset-pulse output |
| hold_off | input | 1 | Keeps the checker idle and cleared while high |
| reset_req | output | 1 | One-cycle request for a new reset pulse |

## Verification
The two functions that can coincide are timekeeping (a millisecond tick advancing the count) and trigger judgement (a watchdog change being compared against the window). The bench provokes the coincidence on purpose. It drives a tick and a toggle in the same cycle at the upper window bound, where the change must be accepted. It does the same one count below the lower bound, where it must be a fault. The random rounds also hit this case now and then at arbitrary counts. A bench model judges each such cycle on the count before the tick and predicts `reset_req` one cycle later.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic accept;  // valid trigger, restart count
        logic fault;   // early, late or missing trigger
        logic bump;    // plain tick, advance count
    } verdict_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned top;
        top = (a > b) ? a : b;
        return $clog2(top + 1);
    endfunction

endpackage

// File: rtl/wdw_edge_sense.sv
module wdw_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic rp_level,
    input  logic wd_in,
    output logic rp_fall,
    output logic wd_toggle
);
    logic rp_q;
    logic wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q <= 1'b0;
            wd_q <= wd_in;
        end else begin
            rp_q <= rp_level;
            wd_q <= wd_in;
        end
    end

    assign rp_fall   = rp_q & ~rp_level;
    assign wd_toggle = wd_q ^ wd_in;
endmodule

// File: rtl/wdw_tick_counter.sv
module wdw_tick_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdw_window_judge.sv
module wdw_window_judge
    import wdw_pkg::*;
#(
    parameter int START_MAX = 500,
    parameter int WIN_MIN   = 200,
    parameter int WIN_MAX   = 300,
    parameter int CW        = 9
) (
    input  phase_e        phase,
    input  logic [CW-1:0] cnt,
    input  logic          toggle,
    input  logic          tick,
    output verdict_t      verdict
);
    localparam logic [CW-1:0] LIM_START = CW'(START_MAX);
    localparam logic [CW-1:0] LIM_LOW   = CW'(WIN_MIN);
    localparam logic [CW-1:0] LIM_HIGH  = CW'(WIN_MAX);

    always_comb begin
        verdict = '0;
        unique case (phase)
            PH_START: begin
                if (toggle) begin
                    verdict.accept = 1'b1;
                end else if (tick) begin
                    if (cnt == LIM_START) verdict.fault = 1'b1;
                    else                  verdict.bump  = 1'b1;
                end
            end
            PH_RUN: begin
                if (toggle) begin
                    if (cnt < LIM_LOW) verdict.fault  = 1'b1;
                    else               verdict.accept = 1'b1;
                end else if (tick) begin
                    if (cnt == LIM_HIGH) verdict.fault = 1'b1;
                    else                 verdict.bump  = 1'b1;
                end
            end
            default: verdict = '0;
        endcase
    end
endmodule

// File: rtl/wdw_trigger_checker.sv
module wdw_trigger_checker
    import wdw_pkg::*;
#(
    parameter int START_MAX = 500,
    parameter int WIN_MIN   = 200,
    parameter int WIN_MAX   = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1ms,
    input  logic wd_in,
    input  logic rp_level,
    input  logic hold_off,
    output logic reset_req
);
    localparam int CW = cnt_width(START_MAX, WIN_MAX);

    phase_e        state_q, state_d;
    logic          req_q, req_d;
    logic          rp_fall, wd_toggle;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt_q;
    verdict_t      verdict;

    wdw_edge_sense u_edges (
        .clk       (clk),
        .rst       (rst),
        .rp_level  (rp_level),
        .wd_in     (wd_in),
        .rp_fall   (rp_fall),
        .wd_toggle (wd_toggle)
    );

    wdw_window_judge #(
        .START_MAX (START_MAX),
        .WIN_MIN   (WIN_MIN),
        .WIN_MAX   (WIN_MAX),
        .CW        (CW)
    ) u_judge (
        .phase   (state_q),
        .cnt     (cnt_q),
        .toggle  (wd_toggle),
        .tick    (tick_1ms),
        .verdict (verdict)
    );

    wdw_tick_counter #(
        .CW (CW)
    ) u_count (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt_q)
    );

    // hold_off outranks a new arm, which outranks any verdict
    always_comb begin
        state_d = state_q;
        req_d   = 1'b0;
        cnt_clr = 1'b0;
        if (hold_off) begin
            state_d = PH_IDLE;
            cnt_clr = 1'b1;
        end else if (rp_fall) begin
            state_d = PH_START;
            cnt_clr = 1'b1;
        end else if (verdict.fault) begin
            state_d = PH_IDLE;
            req_d   = 1'b1;
            cnt_clr = 1'b1;
        end else if (verdict.accept) begin
            state_d = PH_RUN;
            cnt_clr = 1'b1;
        end
        cnt_inc = verdict.bump & ~cnt_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
        end
    end

    assign reset_req = req_q;
endmodule

// File: rtl/wdw_trigger_checker_sva.sv
module wdw_trigger_checker_sva
    import wdw_pkg::*;
#(
    parameter int START_MAX = 500,
    parameter int WIN_MIN   = 200,
    parameter int WIN_MAX   = 300,
    parameter int CW        = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_1ms,
    input logic          wd_in,
    input logic          rp_level,
    input logic          hold_off,
    input logic          reset_req,
    input phase_e        phase,
    input logic [CW-1:0] cnt
);
    logic chk_rp_q, chk_wd_q, armed_q;
    logic chk_fall, chk_edge;

    assign chk_fall = chk_rp_q & ~rp_level;
    assign chk_edge = chk_wd_q ^ wd_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_rp_q <= 1'b0;
            chk_wd_q <= wd_in;
            armed_q  <= 1'b0;
        end else begin
            chk_rp_q <= rp_level;
            chk_wd_q <= wd_in;
            if (hold_off)       armed_q <= 1'b0;
            else if (chk_fall)  armed_q <= 1'b1;
            else if (reset_req) armed_q <= 1'b0;
        end
    end

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    p_req_needs_arm_r9: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> armed_q);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> !reset_req);

    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        hold_off |=> !reset_req);

    p_rearm_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        chk_fall |=> (!reset_req && phase == PH_START));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(START_MAX));

    p_early_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && chk_edge && cnt < CW'(WIN_MIN) && !hold_off && !chk_fall)
        |=> reset_req);

    p_late_fault_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && tick_1ms && !chk_edge && cnt == CW'(WIN_MAX) && !hold_off && !chk_fall)
        |=> reset_req);

    p_start_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START && chk_edge && !hold_off && !chk_fall)
        |=> (!reset_req && phase == PH_RUN && cnt == '0));
endmodule

bind wdw_trigger_checker wdw_trigger_checker_sva #(
    .START_MAX (START_MAX),
    .WIN_MIN   (WIN_MIN),
    .WIN_MAX   (WIN_MAX),
    .CW        (CW)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .tick_1ms  (tick_1ms),
    .wd_in     (wd_in),
    .rp_level  (rp_level),
    .hold_off  (hold_off),
    .reset_req (reset_req),
    .phase     (state_q),
    .cnt       (cnt_q)
);

// File: tb/wdw_trigger_checker_tb_top.sv
module wdw_trigger_checker_tb_top;
    localparam int T_START = 500;
    localparam int T_LOW   = 200;
    localparam int T_HIGH  = 300;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, tick_1ms, wd_in, rp_level, hold_off;
    logic reset_req;

    wdw_trigger_checker dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_1ms  (tick_1ms),
        .wd_in     (wd_in),
        .rp_level  (rp_level),
        .hold_off  (hold_off),
        .reset_req (reset_req)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int m_ph = 0;   // 0 idle, 1 start-up, 2 windowed
    int m_cnt = 0;
    bit m_rp = 1'b0;
    bit cur_rp = 1'b0;

    function automatic bit predict_fault(int ph, int c, bit tog, bit tk);
        if (ph == 1) return !tog && tk && (c == T_START);
        if (ph == 2) begin
            if (tog) return c < T_LOW;
            return tk && (c == T_HIGH);
        end
        return 1'b0;
    endfunction

    task automatic check(bit got, bit exp, string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: reset_req=%0b expected %0b (time %0t)", tag, got, exp, $time);
        end
    endtask

    // one clock cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(bit tog, bit tk, bit rpv, bit hld, string tag);
        bit ef;
        bit fall;
        if (tog) wd_in = ~wd_in;
        tick_1ms = tk;
        rp_level = rpv;
        hold_off = hld;
        @(posedge clk);
        fall = m_rp & ~rpv;
        m_rp = rpv;
        ef = 1'b0;
        if (hld) begin
            m_ph = 0; m_cnt = 0;
        end else if (fall) begin
            m_ph = 1; m_cnt = 0;
        end else begin
            ef = predict_fault(m_ph, m_cnt, tog, tk);
            if (ef) begin
                m_ph = 0; m_cnt = 0;
            end else if (tog && m_ph != 0) begin
                m_ph = 2; m_cnt = 0;
            end else if (tk && m_ph != 0) begin
                m_cnt++;
            end
        end
        @(negedge clk);
        check(reset_req, ef, tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b1, cur_rp, 1'b0, tag);
            cyc(1'b0, 1'b0, cur_rp, 1'b0, tag);
            cyc(1'b0, 1'b0, cur_rp, 1'b0, tag);
        end
    endtask

    task automatic toggle(string tag);
        cyc(1'b1, 1'b0, cur_rp, 1'b0, tag);
        cyc(1'b0, 1'b0, cur_rp, 1'b0, tag);
    endtask

    task automatic arm(string tag);
        cur_rp = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, tag);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, tag);
        cur_rp = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below 190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        k = $urandom(32'h5eed_0042);
        rst = 1'b1; tick_1ms = 1'b0; wd_in = 1'b0; rp_level = 1'b0; hold_off = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reset_req, 1'b0, "R1");

        // R2: idle ignores toggles and time, a rising rp is not an arm
        ticks(20, "R2");
        toggle("R2");
        ticks(550, "R2");
        toggle("R2"); toggle("R2");
        cur_rp = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R2");
        ticks(520, "R2");
        cur_rp = 1'b0;

        // R3: first trigger at the start-up limit; R5: window bounds
        arm("R3");
        ticks(T_START, "R3");
        toggle("R3");
        ticks(T_LOW, "R5");
        toggle("R5");
        ticks(T_HIGH, "R5");
        toggle("R5");
        ticks(250, "R5");
        toggle("R5");
        // R6: one count early
        ticks(T_LOW - 1, "R6");
        toggle("R6");
        // R9: idle after the request
        ticks(600, "R9");
        toggle("R9");

        // R4: missing first trigger
        arm("R4");
        ticks(T_START + 1, "R4");
        ticks(5, "R9");

        // R7: missing trigger in windowed phase
        arm("R7");
        toggle("R7");
        ticks(T_HIGH + 1, "R7");

        // R8: tick and toggle together at both window edges
        arm("R8");
        toggle("R8");
        ticks(T_HIGH, "R8");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        ticks(T_LOW - 1, "R8");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R8");

        // R10: hold_off clears, suppresses, and disarms
        arm("R10");
        toggle("R10");
        ticks(150, "R10");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, "R10");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R10");
        ticks(400, "R10");
        toggle("R10");
        arm("R10");
        ticks(T_START, "R10");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R10");
        ticks(T_START + 5, "R10");

        // R11: re-arm while in the windowed phase
        arm("R11");
        toggle("R11");
        ticks(250, "R11");
        arm("R11");
        ticks(450, "R11");
        toggle("R11");
        ticks(T_LOW + 10, "R11");
        toggle("R11");

        // random rounds
        for (int r = 0; r < 12; r++) begin
            arm("R3");
            ticks($urandom_range(0, T_START), "R3");
            toggle("R3");
            for (int j = 0; j < 4; j++) begin
                k = 185 + $urandom_range(0, 130);
                ticks(k, "R5");
                if ($urandom_range(0, 3) == 0) begin
                    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R8");
                    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R8");
                end else begin
                    toggle("R6");
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule